// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the word address for each beat of a short burst into a synchronous memory. A load strobe captures a full address. The two lowest bits of that address become the starting offset of the burst. Each advance strobe after that moves to the next beat. The low bits then follow one of two orders, chosen by a mode input that is held steady while the block runs. In interleaved order, the low bits are the start offset XOR a beat counter. In linear order, they are the start offset plus the beat counter, wrapping inside the beat field. The bits above the beat field stay at their loaded value for the whole burst.

A clock enable, active low, freezes all state when it is deasserted. The address output comes straight from a register. Whether a beat reads, writes or deselects is decided by the memory core around this block.

Top module: `bag_burst_addr_gen`

## Requirements
- R1: While synchronous reset is high at a clock edge, addr_out becomes zero at that edge.
- R2: At an edge where cen_n is low and load is high, addr_out takes the value of addr_in.
- R3: With mode_ilv high, each advance edge makes the low two bits of addr_out equal start XOR beat. Start is the low two bits captured at the last load. Beat counts the advances since that load, modulo 4. Start 01 gives 01, 00, 11, 10.
- R4: With mode_ilv low, each advance edge makes the low two bits equal (start + beat) modulo 4. Start 11 gives 11, 00, 01, 10.
- R5: An advance never changes addr_out bits above bit 1. A wrap of the low bits does not carry into them.
- R6: The fifth address of a burst (beat 4) equals the first, and the sequence then repeats.
- R7: At an edge where cen_n is high, addr_out holds its value, whatever load, adv and addr_in are.
- R8: When load and adv are both high with cen_n low, load wins and addr_in is captured.
- R9: At an edge where cen_n is low and both load and adv are low, addr_out holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cen_n | input | 1 | Clock enable, active low |
| load | input | 1 | Capture addr_in and start a new burst |
| adv | input | 1 | Step to the next beat of the burst |
| mode_ilv | input | 1 | 1 = interleaved (XOR) order, 0 = linear wrap order |
| addr_in | input | ADDR_W (19) | Address to capture on load |
| addr_out | output | ADDR_W (19) | Current beat address, registered |

## Verification
The assertions check five behaviours on every cycle: that a stall or an idle cycle holds the address, that a load captures the input, that the upper bits stay fixed on an advance, and that each advance yields the XOR or sum of the captured start and a beat count the checker keeps for itself. Other behaviours need planned stimulus and appear only in the bench's scenarios. These are the wrap back to the first address after four beats, load winning over advance, and full sequences for every start offset under both orders with several upper-bit patterns.

// File: rtl/bag_pkg.sv
package bag_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_STEP  = 2'd2,
    OP_STALL = 2'd3
  } bag_op_e;

  // load has priority over advance; a masked clock overrides both
  function automatic bag_op_e bag_decode(logic cen_n, logic ld, logic adv);
    if (cen_n)    return OP_STALL;
    else if (ld)  return OP_LOAD;
    else if (adv) return OP_STEP;
    else          return OP_IDLE;
  endfunction

endpackage

// File: rtl/bag_base_reg.sv
module bag_base_reg
  import bag_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int BEAT_W = 2,
  localparam int HI_W  = ADDR_W - BEAT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  bag_op_e           op,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [HI_W-1:0]   hi_nxt,
  output logic [BEAT_W-1:0] start_nxt
);

  logic [HI_W-1:0]   hi_q;
  logic [BEAT_W-1:0] start_q;

  always_comb begin
    if (op == OP_LOAD) begin
      hi_nxt    = addr_in[ADDR_W-1:BEAT_W];
      start_nxt = addr_in[BEAT_W-1:0];
    end else begin
      hi_nxt    = hi_q;
      start_nxt = start_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q    <= '0;
      start_q <= '0;
    end else begin
      hi_q    <= hi_nxt;
      start_q <= start_nxt;
    end
  end

endmodule

// File: rtl/bag_beat_ctr.sv
module bag_beat_ctr
  import bag_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  bag_op_e           op,
  output logic [BEAT_W-1:0] beat_nxt
);

  logic [BEAT_W-1:0] beat_q;

  always_comb begin
    unique case (op)
      OP_LOAD: beat_nxt = '0;
      OP_STEP: beat_nxt = beat_q + BEAT_W'(1);
      default: beat_nxt = beat_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) beat_q <= '0;
    else     beat_q <= beat_nxt;
  end

endmodule

// File: rtl/bag_seq.sv
module bag_seq #(
  parameter int BEAT_W = 2
) (
  input  logic              mode_ilv,
  input  logic [BEAT_W-1:0] start,
  input  logic [BEAT_W-1:0] beat,
  output logic [BEAT_W-1:0] offset
);

  logic [BEAT_W-1:0] off_xor;
  logic [BEAT_W-1:0] off_add;

  // the sum drops its carry so the order wraps inside the beat field
  always_comb begin
    off_xor = start ^ beat;
    off_add = start + beat;
    offset  = mode_ilv ? off_xor : off_add;
  end

endmodule

// File: rtl/bag_burst_addr_gen.sv
module bag_burst_addr_gen
  import bag_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cen_n,
  input  logic              load,
  input  logic              adv,
  input  logic              mode_ilv,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out
);

  localparam int HI_W = ADDR_W - BEAT_W;

  bag_op_e           op;
  logic [HI_W-1:0]   hi_nxt;
  logic [BEAT_W-1:0] start_nxt;
  logic [BEAT_W-1:0] beat_nxt;
  logic [BEAT_W-1:0] off_nxt;
  logic [ADDR_W-1:0] addr_q;

  assign op = bag_decode(cen_n, load, adv);

  bag_base_reg #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_base (
    .clk(clk), .rst(rst), .op(op), .addr_in(addr_in),
    .hi_nxt(hi_nxt), .start_nxt(start_nxt)
  );

  bag_beat_ctr #(.BEAT_W(BEAT_W)) u_beat (
    .clk(clk), .rst(rst), .op(op), .beat_nxt(beat_nxt)
  );

  bag_seq #(.BEAT_W(BEAT_W)) u_seq (
    .mode_ilv(mode_ilv), .start(start_nxt), .beat(beat_nxt), .offset(off_nxt)
  );

  // output register changes only on load or step, so a mode wiggle in idle or stall is invisible
  always_ff @(posedge clk) begin
    if (rst)
      addr_q <= '0;
    else if (op == OP_LOAD || op == OP_STEP)
      addr_q <= {hi_nxt, off_nxt};
  end

  assign addr_out = addr_q;

endmodule

// File: rtl/bag_burst_addr_chk.sv
module bag_burst_addr_chk #(
  parameter int ADDR_W = 19,
  parameter int BEAT_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              cen_n,
  input logic              load,
  input logic              adv,
  input logic              mode_ilv,
  input logic [ADDR_W-1:0] addr_in,
  input logic [ADDR_W-1:0] addr_out
);

  logic [BEAT_W-1:0] sh_start;
  logic [BEAT_W-1:0] sh_beat;
  logic [BEAT_W-1:0] sh_inc;
  logic [BEAT_W-1:0] exp_ilv;
  logic [BEAT_W-1:0] exp_lin;
  logic              step;

  assign step    = !cen_n && !load && adv;
  assign sh_inc  = sh_beat + BEAT_W'(1);
  assign exp_ilv = sh_start ^ sh_inc;
  assign exp_lin = sh_start + sh_inc;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_start <= '0;
      sh_beat  <= '0;
    end else if (!cen_n && load) begin
      sh_start <= addr_in[BEAT_W-1:0];
      sh_beat  <= '0;
    end else if (step) begin
      sh_beat  <= sh_inc;
    end
  end

  a_r1_reset_zero: assert property (@(posedge clk) rst |=> addr_out == '0);

  a_r2_load_capture: assert property (@(posedge clk) disable iff (rst)
    (!cen_n && load) |=> addr_out == $past(addr_in));

  a_r3_ilv_order: assert property (@(posedge clk) disable iff (rst)
    (step && mode_ilv) |=> addr_out[BEAT_W-1:0] == $past(exp_ilv));

  a_r4_lin_order: assert property (@(posedge clk) disable iff (rst)
    (step && !mode_ilv) |=> addr_out[BEAT_W-1:0] == $past(exp_lin));

  a_r5_upper_fixed: assert property (@(posedge clk) disable iff (rst)
    step |=> addr_out[ADDR_W-1:BEAT_W] == $past(addr_out[ADDR_W-1:BEAT_W]));

  a_r7_stall_hold: assert property (@(posedge clk) disable iff (rst)
    cen_n |=> $stable(addr_out));

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!cen_n && !load && !adv) |=> $stable(addr_out));

endmodule

bind bag_burst_addr_gen bag_burst_addr_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
  .clk(clk), .rst(rst), .cen_n(cen_n), .load(load), .adv(adv),
  .mode_ilv(mode_ilv), .addr_in(addr_in), .addr_out(addr_out)
);

// File: tb/bag_burst_addr_gen_bench.sv
module bag_burst_addr_gen_bench;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 19;
  localparam int BEAT_W = 2;
  localparam int HI_W   = ADDR_W - BEAT_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cen_n = 1'b0;
  logic              load = 1'b0;
  logic              adv = 1'b0;
  logic              mode_ilv = 1'b0;
  logic [ADDR_W-1:0] addr_in = '0;
  logic [ADDR_W-1:0] addr_out;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bag_burst_addr_gen #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_bag_burst_addr_gen (
    .clk(clk), .rst(rst), .cen_n(cen_n), .load(load), .adv(adv),
    .mode_ilv(mode_ilv), .addr_in(addr_in), .addr_out(addr_out)
  );

  task automatic check(input string tag, input logic [ADDR_W-1:0] exp);
    checks++;
    if (addr_out !== exp) begin
      errors++;
      $display("FAIL %s: addr_out=%05h expected=%05h", tag, addr_out, exp);
    end
  endtask

  // inputs change 1 time unit after the edge; addr_out is then stable for that cycle
  task automatic cyc(input logic c, input logic l, input logic a, input logic [ADDR_W-1:0] ad);
    cen_n = c; load = l; adv = a; addr_in = ad;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [HI_W-1:0] upper_pat(input int u);
    case (u)
      0:       return '0;
      1:       return '1;
      default: return HI_W'(32'h0001_A5A5);
    endcase
  endfunction

  initial begin
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] held;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset", '0);
    rst = 1'b0;

    for (int m = 0; m < 2; m++) begin
      mode_ilv = m[0];
      for (int u = 0; u < 3; u++) begin
        for (int s = 0; s < 4; s++) begin
          base = {upper_pat(u), 2'(s)};
          cyc(0, 1, 0, base);
          check("R2 load", base);
          for (int k = 1; k <= 6; k++) begin
            logic [1:0] low;
            low = (m == 1) ? (2'(s) ^ 2'(k)) : 2'(s + k);
            cyc(0, 0, 1, ~base);
            if (k >= 4)      check("R6 wrap R5", {upper_pat(u), low});
            else if (m == 1) check("R3 ilv R5", {upper_pat(u), low});
            else             check("R4 lin R5", {upper_pat(u), low});
          end
        end
      end
    end

    // stall and idle holds
    mode_ilv = 1'b0;
    cyc(0, 1, 0, 19'h55556);
    cyc(0, 0, 1, '0);
    check("R4 step", 19'h55557);
    held = 19'h55557;
    for (int i = 0; i < 3; i++) begin
      cyc(1, i[0], 1, 19'h7FFFC);
      check("R7 stall", held);
    end
    mode_ilv = 1'b1;
    cyc(1, 0, 0, '0);
    check("R7 stall mode", held);
    mode_ilv = 1'b0;
    for (int i = 0; i < 2; i++) begin
      cyc(0, 0, 0, 19'h12345);
      check("R9 idle", held);
    end
    cyc(0, 0, 1, '0);
    check("R4 after stall", 19'h55554);

    // load and advance together
    cyc(0, 1, 1, 19'h3C3C1);
    check("R8 priority", 19'h3C3C1);
    mode_ilv = 1'b1;
    cyc(0, 0, 1, '0);
    check("R3 after priority", 19'h3C3C0);

    // reset in mid-burst
    rst = 1'b1;
    cyc(0, 0, 1, '0);
    check("R1 mid reset", '0);
    rst = 1'b0;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule